// File: doc/BRIEF.md
# Floating-Point Register Stack Controller

This block keeps the bookkeeping state of an eight-entry floating-point register stack. It holds a rotating top-of-stack pointer, a two-bit tag and a 64-bit value for each physical slot, a 16-bit control word and a 16-bit status word. A sequencer drives it with single-cycle commands. Each command pushes, pops, frees or swaps entries, moves the pointer, classifies the top entry into condition codes, loads the control word or snapshots the status word. No arithmetic happens here. The block only tracks which slot holds what and reports on it.

Every operand is named by a logical index. The block turns that index into a physical slot by adding the pointer, so the datapath never needs to know where the stack currently sits. The status word is always presented with the live pointer placed in its pointer field. The rounding mode is decoded from the control word and kept on a port of its own.

Top module: `fstk_regctl`

## Requirements
- R1: Logical index i, on a command or on the read port (`rd_idx`), addresses physical slot (top + i) mod 8. The read port shows that slot's value and tag combinationally.
- R2: Reset and the init command (opcode 1) both set the pointer to 0, the control word to 0x037F, the status word to 0, the rounding mode to 0 and every tag to empty (code 3). Init leaves the stored values alone.
- R3: `status_live` equals the stored status ANDed with 0xC7FF, with the pointer in bits 13:11. The read-status command (opcode 13) copies `status_live` into `status_capture` one cycle later, and `status_capture` holds that value until the next read-status command.
- R4: Clear-exceptions (opcode 9) zeroes status bits 7:0 and keeps bits 15:8.
- R5: Free (opcode 4) sets the tag of ST(i) to empty and leaves the pointer unchanged. Free-and-pop (opcode 5) does the same and then pops.
- R6: Increment-pointer (opcode 7) and decrement-pointer (opcode 8) move the pointer by one, wrapping modulo 8. They change no tag and no value.
- R7: Push (opcode 2) decrements the pointer, writes `cmd_data` into the new ST(0) and sets its tag to valid (code 0). Pop (opcode 3) sets the tag of ST(0) to empty and then increments the pointer.
- R8: Exchange (opcode 6) swaps both value and tag between ST(0) and ST(i).
- R9: Examine (opcode 10) first clears C0, C1, C2 and C3, which are status bits 8, 9, 10 and 14. It then sets C0 and C3 if ST(0) is tagged empty, otherwise C3 if ST(0) is zero, otherwise C2. It also sets C1 if the sign bit (bit 63) of ST(0) is set. "Zero" means bits 62:0 are all zero.
- R10: Test (opcode 11) clears C0, C2 and C3 and leaves C1 unchanged. It then sets C3 if ST(0) is zero, or C0 if ST(0) is nonzero with its sign bit set. Negative zero therefore sets C3.
- R11: Load-control (opcode 12) writes `cmd_data[15:0]` into the control word, and `round_mode` becomes `cmd_data[11:10]` in the same cycle.
- R12: Opcodes 0, 14 and 15 change nothing. Any command presented with `cmd_valid` low also changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 4 | Command opcode |
| cmd_idx | input | PTR_W (3) | Logical stack index i for the command |
| cmd_data | input | VAL_W (64) | Push value; the low 16 bits are the new control word |
| rd_idx | input | PTR_W (3) | Logical index for the observation read port |
| rd_value | output | VAL_W (64) | Value at logical rd_idx |
| rd_tag | output | 2 | Tag at logical rd_idx |
| top_ptr | output | PTR_W (3) | Current top-of-stack pointer |
| control_word | output | 16 | Control word |
| round_mode | output | 2 | Rounding mode from control bits 11:10 |
| status_live | output | 16 | Status word with the live pointer spliced in |
| status_capture | output | 16 | Status snapshot taken by read-status |

## Verification
The read port is combinational from the current state, so it can be read in the same cycle as a command that rewrites the slot it addresses. The bench provokes this by holding `rd_idx` at 0 while a push is on the command port. It samples just after the driving edge and expects the pre-push ST(0) and pointer. It samples again one cycle later and expects the pushed value, the valid tag and the decremented pointer. Free-and-pop is the other same-cycle case: two tag writes can land on different slots at one edge. The bench frees a slot two below the top and then checks both that slot's tag and the old top's tag.

// File: rtl/fstk_pkg.sv
package fstk_pkg;

   localparam int unsigned CC0_BIT  = 8;
   localparam int unsigned CC1_BIT  = 9;
   localparam int unsigned CC2_BIT  = 10;
   localparam int unsigned CC3_BIT  = 14;
   localparam int unsigned TOPF_LSB = 11;
   localparam int unsigned TOPF_W   = 3;

   localparam logic [15:0] SW_KEEP_MASK = 16'hC7FF;
   localparam logic [15:0] SW_CLEX_MASK = 16'hFF00;
   localparam logic [15:0] CW_DEFAULT   = 16'h037F;

   typedef logic [1:0] tag_t;
   localparam tag_t TAG_VALID = 2'd0;
   localparam tag_t TAG_EMPTY = 2'd3;

   typedef enum logic [3:0] {
      OP_NOP   = 4'd0,
      OP_INIT  = 4'd1,
      OP_PUSH  = 4'd2,
      OP_POP   = 4'd3,
      OP_FREE  = 4'd4,
      OP_FREEP = 4'd5,
      OP_XCHG  = 4'd6,
      OP_INCP  = 4'd7,
      OP_DECP  = 4'd8,
      OP_CLEX  = 4'd9,
      OP_EXAM  = 4'd10,
      OP_TEST  = 4'd11,
      OP_LDCW  = 4'd12,
      OP_RDSW  = 4'd13
   } fop_e;

   typedef struct packed {
      logic init;
      logic push;
      logic pop;
      logic free_only;
      logic free_pop;
      logic xchg;
      logic incp;
      logic decp;
      logic clex;
      logic exam;
      logic test;
      logic ldcw;
      logic rdsw;
   } fctl_t;

endpackage

// File: rtl/fstk_topptr.sv
module fstk_topptr
   import fstk_pkg::*;
#(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned PTR_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  fctl_t            ctl,
   input  logic [PTR_W-1:0] cmd_idx,
   input  logic [PTR_W-1:0] rd_idx,
   output logic [PTR_W-1:0] top_q,
   output logic [PTR_W-1:0] slot_cmd,
   output logic [PTR_W-1:0] slot_rd,
   output logic [PTR_W-1:0] slot_new
);

   localparam logic [PTR_W-1:0] STEP = PTR_W'(1);

   logic step_down;
   logic step_up;

   assign step_down = ctl.push | ctl.decp;
   assign step_up   = ctl.pop | ctl.free_pop | ctl.incp;

   // Pointer width equals log2(DEPTH), so plain add/sub wraps modulo DEPTH.
   assign slot_cmd = top_q + cmd_idx;
   assign slot_rd  = top_q + rd_idx;
   assign slot_new = top_q - STEP;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         top_q <= '0;
      end else if (ctl.init) begin
         top_q <= '0;
      end else if (step_down) begin
         top_q <= top_q - STEP;
      end else if (step_up) begin
         top_q <= top_q + STEP;
      end
   end

endmodule

// File: rtl/fstk_slotfile.sv
module fstk_slotfile
   import fstk_pkg::*;
#(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned PTR_W = $clog2(DEPTH),
   parameter int unsigned VAL_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  fctl_t            ctl,
   input  logic [PTR_W-1:0] top,
   input  logic [PTR_W-1:0] slot_cmd,
   input  logic [PTR_W-1:0] slot_new,
   input  logic [PTR_W-1:0] slot_rd,
   input  logic [VAL_W-1:0] wr_val,
   output logic [VAL_W-1:0] rd_val,
   output tag_t             rd_tag,
   output logic [VAL_W-1:0] top_val,
   output tag_t             top_tag
);

   tag_t             tag_q [DEPTH];
   logic [VAL_W-1:0] val_q [DEPTH];

   logic [DEPTH-1:0] hit_new;
   logic [DEPTH-1:0] hit_top;
   logic [DEPTH-1:0] hit_cmd;
   logic [DEPTH-1:0] kill;

   logic free_any;
   logic pop_any;

   assign free_any = ctl.free_only | ctl.free_pop;
   assign pop_any  = ctl.pop | ctl.free_pop;

   // One set of slot-select decoders per physical slot.
   for (genvar g = 0; g < DEPTH; g++) begin : g_slot_sel
      assign hit_new[g] = (slot_new == PTR_W'(g));
      assign hit_top[g] = (top == PTR_W'(g));
      assign hit_cmd[g] = (slot_cmd == PTR_W'(g));
      assign kill[g]    = (free_any & hit_cmd[g]) | (pop_any & hit_top[g]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < DEPTH; s++) begin
            tag_q[s] <= TAG_EMPTY;
            val_q[s] <= '0;
         end
      end else begin
         for (int s = 0; s < DEPTH; s++) begin
            if (ctl.init) begin
               tag_q[s] <= TAG_EMPTY;
            end else if (ctl.push && hit_new[s]) begin
               tag_q[s] <= TAG_VALID;
               val_q[s] <= wr_val;
            end else if (ctl.xchg && hit_top[s]) begin
               tag_q[s] <= tag_q[slot_cmd];
               val_q[s] <= val_q[slot_cmd];
            end else if (ctl.xchg && hit_cmd[s]) begin
               tag_q[s] <= tag_q[top];
               val_q[s] <= val_q[top];
            end else if (kill[s]) begin
               tag_q[s] <= TAG_EMPTY;
            end
         end
      end
   end

   assign rd_val  = val_q[slot_rd];
   assign rd_tag  = tag_q[slot_rd];
   assign top_val = val_q[top];
   assign top_tag = tag_q[top];

endmodule

// File: rtl/fstk_ctrlstat.sv
module fstk_ctrlstat
   import fstk_pkg::*;
#(
   parameter int unsigned VAL_W       = 64,
   parameter int unsigned PTR_W       = 3,
   parameter bit          SW_SNAPSHOT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  fctl_t            ctl,
   input  logic [15:0]      ld_word,
   input  logic [PTR_W-1:0] top,
   input  logic [VAL_W-1:0] top_val,
   input  tag_t             top_tag,
   output logic [15:0]      control_word,
   output logic [1:0]       round_mode,
   output logic [15:0]      status_live,
   output logic [15:0]      status_capture
);

   logic [15:0]       cw_q;
   logic [15:0]       sw_q;
   logic [15:0]       sw_next;
   logic [1:0]        rm_q;
   logic [TOPF_W-1:0] top_field;
   logic              is_neg;
   logic              is_zero;
   logic              is_empty;

   assign is_neg    = top_val[VAL_W-1];
   assign is_zero   = ~|top_val[VAL_W-2:0];
   assign is_empty  = (top_tag == TAG_EMPTY);
   assign top_field = TOPF_W'(top);

   always_comb begin
      sw_next = sw_q;
      if (ctl.init) begin
         sw_next = '0;
      end else if (ctl.clex) begin
         sw_next = sw_q & SW_CLEX_MASK;
      end else if (ctl.exam) begin
         sw_next[CC0_BIT] = 1'b0;
         sw_next[CC1_BIT] = 1'b0;
         sw_next[CC2_BIT] = 1'b0;
         sw_next[CC3_BIT] = 1'b0;
         if (is_empty) begin
            sw_next[CC0_BIT] = 1'b1;
            sw_next[CC3_BIT] = 1'b1;
         end else if (is_zero) begin
            sw_next[CC3_BIT] = 1'b1;
         end else begin
            sw_next[CC2_BIT] = 1'b1;
         end
         if (is_neg) begin
            sw_next[CC1_BIT] = 1'b1;
         end
      end else if (ctl.test) begin
         sw_next[CC0_BIT] = 1'b0;
         sw_next[CC2_BIT] = 1'b0;
         sw_next[CC3_BIT] = 1'b0;
         if (is_zero) begin
            sw_next[CC3_BIT] = 1'b1;
         end else if (is_neg) begin
            sw_next[CC0_BIT] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cw_q <= CW_DEFAULT;
         rm_q <= CW_DEFAULT[11:10];
         sw_q <= '0;
      end else begin
         sw_q <= sw_next;
         if (ctl.init) begin
            cw_q <= CW_DEFAULT;
            rm_q <= CW_DEFAULT[11:10];
         end else if (ctl.ldcw) begin
            cw_q <= ld_word;
            rm_q <= ld_word[11:10];
         end
      end
   end

   always_comb begin
      status_live = sw_q & SW_KEEP_MASK;
      status_live[TOPF_LSB +: TOPF_W] = top_field;
   end

   if (SW_SNAPSHOT) begin : g_snap_reg
      logic [15:0] cap_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cap_q <= '0;
         end else if (ctl.rdsw) begin
            cap_q <= status_live;
         end
      end
      assign status_capture = cap_q;
   end else begin : g_snap_thru
      assign status_capture = status_live;
   end

   assign control_word = cw_q;
   assign round_mode   = rm_q;

endmodule

// File: rtl/fstk_regctl.sv
module fstk_regctl
   import fstk_pkg::*;
#(
   parameter int unsigned DEPTH       = 8,
   parameter int unsigned VAL_W       = 64,
   parameter bit          SW_SNAPSHOT = 1'b1,
   parameter int unsigned PTR_W       = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [3:0]       cmd_op,
   input  logic [PTR_W-1:0] cmd_idx,
   input  logic [VAL_W-1:0] cmd_data,
   input  logic [PTR_W-1:0] rd_idx,
   output logic [VAL_W-1:0] rd_value,
   output logic [1:0]       rd_tag,
   output logic [PTR_W-1:0] top_ptr,
   output logic [15:0]      control_word,
   output logic [1:0]       round_mode,
   output logic [15:0]      status_live,
   output logic [15:0]      status_capture
);

   if (DEPTH < 2 || DEPTH > 8 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("fstk_regctl: DEPTH must be a power of two from 2 to 8");
   end
   if (PTR_W != $clog2(DEPTH)) begin : g_bad_ptr
      $error("fstk_regctl: PTR_W must equal clog2(DEPTH)");
   end
   if (VAL_W < 16) begin : g_bad_val
      $error("fstk_regctl: VAL_W must be at least 16");
   end

   fctl_t            ctl;
   logic [PTR_W-1:0] slot_cmd;
   logic [PTR_W-1:0] slot_rd;
   logic [PTR_W-1:0] slot_new;
   logic [VAL_W-1:0] top_val;
   tag_t             top_tag;
   tag_t             rd_tag_w;

   always_comb begin
      ctl = '0;
      if (cmd_valid) begin
         case (cmd_op)
            OP_INIT:  ctl.init      = 1'b1;
            OP_PUSH:  ctl.push      = 1'b1;
            OP_POP:   ctl.pop       = 1'b1;
            OP_FREE:  ctl.free_only = 1'b1;
            OP_FREEP: ctl.free_pop  = 1'b1;
            OP_XCHG:  ctl.xchg      = 1'b1;
            OP_INCP:  ctl.incp      = 1'b1;
            OP_DECP:  ctl.decp      = 1'b1;
            OP_CLEX:  ctl.clex      = 1'b1;
            OP_EXAM:  ctl.exam      = 1'b1;
            OP_TEST:  ctl.test      = 1'b1;
            OP_LDCW:  ctl.ldcw      = 1'b1;
            OP_RDSW:  ctl.rdsw      = 1'b1;
            default:  ctl           = '0;
         endcase
      end
   end

   fstk_topptr #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl      (ctl),
      .cmd_idx  (cmd_idx),
      .rd_idx   (rd_idx),
      .top_q    (top_ptr),
      .slot_cmd (slot_cmd),
      .slot_rd  (slot_rd),
      .slot_new (slot_new)
   );

   fstk_slotfile #(.DEPTH(DEPTH), .PTR_W(PTR_W), .VAL_W(VAL_W)) u_slots (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl      (ctl),
      .top      (top_ptr),
      .slot_cmd (slot_cmd),
      .slot_new (slot_new),
      .slot_rd  (slot_rd),
      .wr_val   (cmd_data),
      .rd_val   (rd_value),
      .rd_tag   (rd_tag_w),
      .top_val  (top_val),
      .top_tag  (top_tag)
   );

   assign rd_tag = rd_tag_w;

   fstk_ctrlstat #(.VAL_W(VAL_W), .PTR_W(PTR_W), .SW_SNAPSHOT(SW_SNAPSHOT)) u_cs (
      .clk            (clk),
      .rst_n          (rst_n),
      .ctl            (ctl),
      .ld_word        (cmd_data[15:0]),
      .top            (top_ptr),
      .top_val        (top_val),
      .top_tag        (top_tag),
      .control_word   (control_word),
      .round_mode     (round_mode),
      .status_live    (status_live),
      .status_capture (status_capture)
   );

endmodule

// File: rtl/fstk_regctl_chk.sv
module fstk_regctl_chk
   import fstk_pkg::*;
#(
   parameter int unsigned PTR_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_valid,
   input logic [3:0]       cmd_op,
   input logic [15:0]      cmd_lo,
   input logic [PTR_W-1:0] top_ptr,
   input logic [15:0]      control_word,
   input logic [1:0]       round_mode,
   input logic [15:0]      status_live,
   input logic [15:0]      status_capture
);

   localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

   assert_init_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_INIT) |=>
         (top_ptr == '0 && control_word == CW_DEFAULT && status_live == 16'h0000 && round_mode == 2'd0));

   assert_snapshot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_RDSW) |=> (status_capture == $past(status_live)));

   assert_clex_keeps_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_CLEX) |=>
         (status_live[15:8] == $past(status_live[15:8]) && status_live[7:0] == 8'h00));

   assert_incp_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_INCP) |=> (top_ptr == $past(top_ptr) + ONE));

   assert_decp_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_DECP) |=> (top_ptr == $past(top_ptr) - ONE));

   assert_push_moves_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_PUSH) |=> (top_ptr == $past(top_ptr) - ONE));

   assert_free_keeps_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_FREE) |=> $stable(top_ptr));

   assert_exam_one_class_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_EXAM) |=> ((status_live[14] ^ status_live[10]) && !(status_live[8] && !status_live[14])));

   assert_test_clears_c2_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_TEST) |=> (!status_live[10] && !(status_live[8] && status_live[14])));

   assert_round_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_LDCW) |=> (round_mode == $past(cmd_lo[11:10]) && control_word == $past(cmd_lo)));

   assert_idle_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_valid || cmd_op == OP_NOP || cmd_op > OP_RDSW) |=>
         ($stable(top_ptr) && $stable(control_word) && $stable(status_live) && $stable(status_capture)));

endmodule

bind fstk_regctl fstk_regctl_chk #(.PTR_W(PTR_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cmd_valid      (cmd_valid),
   .cmd_op         (cmd_op),
   .cmd_lo         (cmd_data[15:0]),
   .top_ptr        (top_ptr),
   .control_word   (control_word),
   .round_mode     (round_mode),
   .status_live    (status_live),
   .status_capture (status_capture)
);

// File: tb/fstk_regctl_tb.sv
module fstk_regctl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [3:0]  cmd_op = 4'd0;
   logic [2:0]  cmd_idx = 3'd0;
   logic [63:0] cmd_data = 64'd0;
   logic [2:0]  rd_idx = 3'd0;
   logic [63:0] rd_value;
   logic [1:0]  rd_tag;
   logic [2:0]  top_ptr;
   logic [15:0] control_word;
   logic [1:0]  round_mode;
   logic [15:0] status_live;
   logic [15:0] status_capture;

   int checks = 0;
   int errors = 0;

   localparam logic [63:0] NEG2  = 64'hC000_0000_0000_0000;
   localparam logic [63:0] NEGZ  = 64'h8000_0000_0000_0000;
   localparam logic [63:0] POS1  = 64'h3FF0_0000_0000_0000;

   always #4 clk = ~clk;

   fstk_regctl u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_idx(cmd_idx), .cmd_data(cmd_data), .rd_idx(rd_idx),
      .rd_value(rd_value), .rd_tag(rd_tag), .top_ptr(top_ptr),
      .control_word(control_word), .round_mode(round_mode),
      .status_live(status_live), .status_capture(status_capture)
   );

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
      end
   endtask

   task automatic issue(input logic [3:0] op, input logic [2:0] idx, input logic [63:0] d);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_idx = idx; cmd_data = d;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 4'd0; cmd_idx = 3'd0; cmd_data = 64'd0;
   endtask

   task automatic peek(input logic [2:0] i, output logic [63:0] v, output logic [1:0] t);
      rd_idx = i;
      #1;
      v = rd_value;
      t = rd_tag;
   endtask

   task automatic t_reset;
      logic [63:0] v; logic [1:0] t;
      chk("R2", "reset top", 64'(top_ptr), 64'd0);
      chk("R2", "reset cw", 64'(control_word), 64'h037F);
      chk("R2", "reset status", 64'(status_live), 64'h0);
      chk("R2", "reset round", 64'(round_mode), 64'd0);
      chk("R3", "reset capture", 64'(status_capture), 64'h0);
      peek(3'd0, v, t);
      chk("R2", "reset tag", 64'(t), 64'd3);
   endtask

   task automatic t_ldcw;
      issue(4'd12, 3'd0, 64'h0C7F);
      chk("R11", "cw load", 64'(control_word), 64'h0C7F);
      chk("R11", "round 3", 64'(round_mode), 64'd3);
      issue(4'd12, 3'd0, 64'h0400);
      chk("R11", "round 1", 64'(round_mode), 64'd1);
      issue(4'd1, 3'd0, 64'd0);
      chk("R2", "init cw", 64'(control_word), 64'h037F);
      chk("R2", "init round", 64'(round_mode), 64'd0);
   endtask

   task automatic t_exam;
      issue(4'd1, 3'd0, 64'd0);
      issue(4'd10, 3'd0, 64'd0);
      chk("R9", "exam empty", 64'(status_live), 64'h4100);
      issue(4'd2, 3'd0, NEG2);
      issue(4'd10, 3'd0, 64'd0);
      chk("R9", "exam neg nonzero", 64'(status_live), 64'h3E00);
      issue(4'd2, 3'd0, 64'd0);
      issue(4'd10, 3'd0, 64'd0);
      chk("R9", "exam +0", 64'(status_live), 64'h7000);
      issue(4'd2, 3'd0, NEGZ);
      issue(4'd10, 3'd0, 64'd0);
      chk("R9", "exam -0", 64'(status_live), 64'h6A00);
   endtask

   task automatic t_test;
      issue(4'd1, 3'd0, 64'd0);
      issue(4'd2, 3'd0, NEG2);
      issue(4'd10, 3'd0, 64'd0);
      issue(4'd11, 3'd0, 64'd0);
      chk("R10", "test neg keeps C1", 64'(status_live), 64'h3B00);
      issue(4'd2, 3'd0, NEGZ);
      issue(4'd11, 3'd0, 64'd0);
      chk("R10", "test -0 is zero", 64'(status_live), 64'h7200);
      issue(4'd2, 3'd0, POS1);
      issue(4'd11, 3'd0, 64'd0);
      chk("R10", "test positive", 64'(status_live), 64'h2A00);
   endtask

   task automatic t_clex;
      issue(4'd1, 3'd0, 64'd0);
      issue(4'd10, 3'd0, 64'd0);
      issue(4'd9, 3'd0, 64'd0);
      chk("R4", "clex keeps high byte", 64'(status_live), 64'h4100);
   endtask

   task automatic t_rdsw;
      issue(4'd1, 3'd0, 64'd0);
      issue(4'd2, 3'd0, NEG2);
      issue(4'd10, 3'd0, 64'd0);
      chk("R3", "capture before read", 64'(status_capture), 64'h0);
      issue(4'd13, 3'd0, 64'd0);
      chk("R3", "capture spliced", 64'(status_capture), 64'h3E00);
      issue(4'd7, 3'd0, 64'd0);
      chk("R3", "live follows top", 64'(status_live), 64'h0600);
      chk("R3", "capture held", 64'(status_capture), 64'h3E00);
   endtask

   task automatic t_pushpop;
      logic [63:0] v; logic [1:0] t;
      issue(4'd1, 3'd0, 64'd0);
      issue(4'd2, 3'd0, 64'h1111);
      issue(4'd2, 3'd0, 64'h2222);
      chk("R7", "top after 2 push", 64'(top_ptr), 64'd6);
      peek(3'd0, v, t);
      chk("R7", "ST0 value", v, 64'h2222);
      chk("R7", "ST0 tag", 64'(t), 64'd0);
      peek(3'd1, v, t);
      chk("R1", "ST1 value", v, 64'h1111);
      issue(4'd3, 3'd0, 64'd0);
      chk("R7", "top after pop", 64'(top_ptr), 64'd7);
      peek(3'd0, v, t);
      chk("R7", "ST0 after pop", v, 64'h1111);
      peek(3'd7, v, t);
      chk("R7", "popped tag empty", 64'(t), 64'd3);
      chk("R1", "popped value kept", v, 64'h2222);
   endtask

   task automatic t_incdec;
      logic [63:0] v; logic [1:0] t;
      issue(4'd1, 3'd0, 64'd0);
      issue(4'd2, 3'd0, 64'hAAAA);
      issue(4'd8, 3'd0, 64'd0);
      chk("R6", "decp top", 64'(top_ptr), 64'd6);
      peek(3'd0, v, t);
      chk("R6", "decp leaves tag empty", 64'(t), 64'd3);
      peek(3'd1, v, t);
      chk("R6", "decp keeps value", v, 64'hAAAA);
      issue(4'd7, 3'd0, 64'd0);
      issue(4'd7, 3'd0, 64'd0);
      chk("R6", "incp wraps to 0", 64'(top_ptr), 64'd0);
      peek(3'd7, v, t);
      chk("R1", "ST7 maps to slot 7", v, 64'hAAAA);
      chk("R6", "incp keeps tag", 64'(t), 64'd0);
      issue(4'd8, 3'd0, 64'd0);
      chk("R6", "decp wraps to 7", 64'(top_ptr), 64'd7);
   endtask

   task automatic t_free;
      logic [63:0] v; logic [1:0] t;
      issue(4'd1, 3'd0, 64'd0);
      issue(4'd2, 3'd0, 64'h10);
      issue(4'd2, 3'd0, 64'h20);
      issue(4'd2, 3'd0, 64'h30);
      issue(4'd4, 3'd1, 64'd0);
      chk("R5", "free keeps top", 64'(top_ptr), 64'd5);
      peek(3'd1, v, t);
      chk("R5", "freed tag", 64'(t), 64'd3);
      peek(3'd0, v, t);
      chk("R5", "ST0 untouched", 64'(t), 64'd0);
      issue(4'd5, 3'd2, 64'd0);
      chk("R5", "freep pops", 64'(top_ptr), 64'd6);
      peek(3'd1, v, t);
      chk("R5", "freep addressed tag", 64'(t), 64'd3);
      peek(3'd7, v, t);
      chk("R5", "freep old top tag", 64'(t), 64'd3);
   endtask

   task automatic t_xchg;
      logic [63:0] v; logic [1:0] t;
      issue(4'd1, 3'd0, 64'd0);
      issue(4'd2, 3'd0, 64'hBEEF);
      issue(4'd2, 3'd0, 64'hCAFE);
      issue(4'd6, 3'd1, 64'd0);
      peek(3'd0, v, t);
      chk("R8", "xchg ST0 value", v, 64'hBEEF);
      peek(3'd1, v, t);
      chk("R8", "xchg ST1 value", v, 64'hCAFE);
      issue(4'd6, 3'd2, 64'd0);
      peek(3'd0, v, t);
      chk("R8", "xchg empty tag to ST0", 64'(t), 64'd3);
      peek(3'd2, v, t);
      chk("R8", "xchg ST2 value", v, 64'hBEEF);
      chk("R8", "xchg ST2 tag", 64'(t), 64'd0);
   endtask

   task automatic t_ignore;
      logic [63:0] v; logic [1:0] t;
      issue(4'd1, 3'd0, 64'd0);
      issue(4'd2, 3'd0, 64'h1234);
      issue(4'd14, 3'd1, 64'hFFFF);
      issue(4'd15, 3'd1, 64'hFFFF);
      issue(4'd0, 3'd1, 64'hFFFF);
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 4'd2; cmd_data = 64'h9999;
      @(negedge clk);
      cmd_op = 4'd12; cmd_data = 64'h0C00;
      @(negedge clk);
      cmd_op = 4'd0; cmd_data = 64'd0;
      chk("R12", "top unchanged", 64'(top_ptr), 64'd7);
      chk("R12", "cw unchanged", 64'(control_word), 64'h037F);
      chk("R12", "status unchanged", 64'(status_live), 64'h3800);
      peek(3'd0, v, t);
      chk("R12", "ST0 unchanged", v, 64'h1234);
   endtask

   task automatic t_samecycle;
      logic [63:0] v; logic [1:0] t;
      issue(4'd1, 3'd0, 64'd0);
      issue(4'd2, 3'd0, 64'h55);
      @(negedge clk);
      rd_idx = 3'd0;
      cmd_valid = 1'b1; cmd_op = 4'd2; cmd_data = 64'h66;
      #1;
      chk("R7", "same cycle old ST0", rd_value, 64'h55);
      chk("R7", "same cycle old top", 64'(top_ptr), 64'd7);
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 4'd0; cmd_data = 64'd0;
      peek(3'd0, v, t);
      chk("R7", "next cycle new ST0", v, 64'h66);
      chk("R7", "next cycle tag", 64'(t), 64'd0);
      chk("R7", "next cycle top", 64'(top_ptr), 64'd6);
   endtask

   initial begin
      #8000000;
      errors++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ldcw();
      t_exam();
      t_test();
      t_clex();
      t_rdsw();
      t_pushpop();
      t_incdec();
      t_free();
      t_xchg();
      t_ignore();
      t_samecycle();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule